// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Aggregator

This block keeps one control and status word for each of up to 32 DMA channels and folds every channel's interrupt condition into a per-channel summary register and one shared interrupt line. Each word carries a run control, a no-descriptor-fetch control and a stop-interrupt enable, all read/write. It also carries three sticky event flags (bus error, descriptor start, descriptor end) that the channel engines raise with one-cycle strobes, and two read-only indications: request pending and stopped.

Software clears flags by writing ones. Because writes of zero leave a flag alone and the read-only bits ignore writes, a handler can read a status word and write the same value back. That clears exactly the flags it saw and leaves the controls as they were. On the shared line, the handler reads the summary register and walks its set bits from the lowest upward.

Each channel has a three-state run machine. CH_STOPPED goes to CH_RUNNING when run is 1. CH_RUNNING goes to CH_STOPPED when run is 0 and no beat is in flight, or to CH_DRAINING when run is 0 and a beat is in flight. CH_DRAINING goes to CH_STOPPED when the beat completes, or back to CH_RUNNING if run is set again. The stopped indication is 1 exactly in CH_STOPPED.

Top module: `dmac_stat_top`

## Requirements
- R1: After reset every channel word reads 0x0000_0008 (stopped, all controls and flags clear), the summary register reads 0 and `irq` is 0.
- R2: Channel i's word is at byte address 4*i and the summary register is at 0xF0. In a channel word, bit 31 is run, bit 30 is no-descriptor-fetch, bit 29 is stop-interrupt enable, bit 8 is request pending, bit 3 is stopped, bit 2 is the end flag, bit 1 is the start flag and bit 0 is the bus-error flag. All other bits read 0.
- R3: An event strobe sets its flag on that clock edge, and the flag stays set until software clears it.
- R4: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. Writes to bits 8 and 3 have no effect.
- R5: When an event strobe and a clearing write hit the same flag in the same cycle, the flag stays set.
- R6: Writing back a just-read word clears exactly the flags that were set and leaves run, no-descriptor-fetch and stop-interrupt enable unchanged. A channel word holds its control bits in any cycle without a write to that word.
- R7: The run machine follows the run bit one cycle after the register write. After setting run, the stopped bit still reads 1 in the first cycle and reads 0 from the second cycle on.
- R8: After run is cleared, the stopped bit stays 0 while `beat_busy` for that channel is 1. It becomes 1 one cycle after `beat_busy` falls.
- R9: A channel's summary bit is its bus-error flag, OR its end flag AND its `end_ie` input, OR its start flag AND its `start_ie` input, OR stopped AND stop-interrupt enable.
- R10: `irq` is the OR of all summary bits.
- R11: Writes to the summary address or to an unmapped address change nothing. Reads of an unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| ev_buserr | input | NUM_CH | Bus-error event strobe per channel |
| ev_start | input | NUM_CH | Descriptor-start event strobe per channel |
| ev_end | input | NUM_CH | Descriptor-end event strobe per channel |
| start_ie | input | NUM_CH | Start-interrupt enable from the current descriptor |
| end_ie | input | NUM_CH | End-interrupt enable from the current descriptor |
| beat_busy | input | NUM_CH | A data beat is in flight on the channel |
| req_pend | input | NUM_CH | Peripheral request pending on the channel |
| irq | output | 1 | Shared interrupt line |

## Verification
The embedded assertions watch, on every cycle, the per-flag rules: a strobe sets its flag, a strobe beats a same-cycle clear, a clear without a strobe empties the flag, and the control bits hold when their word is not written. They also check that a channel draining a beat cannot reach the stopped state, and that the shared line stays low with no channel condition. The bench scenarios cover the parts that involve the whole register port:
- the address map and bit layout
- the write-back idiom over a mix of set flags
- the lag between run and the stopped bit
- gating by the descriptor enables and by stop-interrupt enable
- writes to the summary and to unmapped addresses having no effect.

// File: rtl/dmac_stat_pkg.sv
package dmac_stat_pkg;
    localparam int WORD_W   = 32;
    localparam int B_RUN    = 31;
    localparam int B_NODESC = 30;
    localparam int B_STOPIE = 29;
    localparam int B_REQ    = 8;
    localparam int B_STOPPED = 3;
    localparam int B_END    = 2;
    localparam int B_START  = 1;
    localparam int B_BUSERR = 0;

    typedef enum logic [1:0] {
        CH_STOPPED  = 2'd0,
        CH_RUNNING  = 2'd1,
        CH_DRAINING = 2'd2
    } ch_state_e;
endpackage

// File: rtl/dmac_ch_status.sv
module dmac_ch_status
    import dmac_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ev_buserr,
    input  logic              ev_start,
    input  logic              ev_end,
    input  logic              start_ie,
    input  logic              end_ie,
    input  logic              beat_busy,
    input  logic              req_pend,
    output logic [WORD_W-1:0] status_o,
    output logic              irq_cond_o
);
    ch_state_e state_q, state_d;
    logic run_q, nodesc_q, stopie_q;
    logic f_err_q, f_start_q, f_end_q;
    logic clr_err, clr_start, clr_end;
    logic stopped;

    assign clr_err   = wr_hit & wr_data[B_BUSERR];
    assign clr_start = wr_hit & wr_data[B_START];
    assign clr_end   = wr_hit & wr_data[B_END];

    // control bits and sticky flags; an event beats a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            nodesc_q  <= 1'b0;
            stopie_q  <= 1'b0;
            f_err_q   <= 1'b0;
            f_start_q <= 1'b0;
            f_end_q   <= 1'b0;
        end else begin
            if (wr_hit) begin
                run_q    <= wr_data[B_RUN];
                nodesc_q <= wr_data[B_NODESC];
                stopie_q <= wr_data[B_STOPIE];
            end
            f_err_q   <= (f_err_q   & ~clr_err)   | ev_buserr;
            f_start_q <= (f_start_q & ~clr_start) | ev_start;
            f_end_q   <= (f_end_q   & ~clr_end)   | ev_end;
        end
    end

    // run machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    // run machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED:  if (run_q) state_d = CH_RUNNING;
            CH_RUNNING:  if (!run_q) state_d = beat_busy ? CH_DRAINING : CH_STOPPED;
            CH_DRAINING: begin
                if (run_q)           state_d = CH_RUNNING;
                else if (!beat_busy) state_d = CH_STOPPED;
            end
            default:     state_d = CH_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        stopped = (state_q == CH_STOPPED);
        status_o = '0;
        status_o[B_RUN]     = run_q;
        status_o[B_NODESC]  = nodesc_q;
        status_o[B_STOPIE]  = stopie_q;
        status_o[B_REQ]     = req_pend;
        status_o[B_STOPPED] = stopped;
        status_o[B_END]     = f_end_q;
        status_o[B_START]   = f_start_q;
        status_o[B_BUSERR]  = f_err_q;
        irq_cond_o = f_err_q | (f_end_q & end_ie) | (f_start_q & start_ie)
                   | (stopped & stopie_q);
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buserr |=> status_o[B_BUSERR]); // R3
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_end && clr_end) |=> status_o[B_END]); // R5
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !ev_buserr) |=> !status_o[B_BUSERR]); // R4
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(status_o[B_RUN:B_STOPIE])); // R6
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o[B_STOPPED] && beat_busy) |=> !status_o[B_STOPPED]); // R8
endmodule

// File: rtl/dmac_irq_merge.sv
module dmac_irq_merge #(
    parameter int NUM_CH = 32,
    parameter int SUM_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cond,
    output logic [SUM_W-1:0]  summary_o,
    output logic              irq_o
);
    localparam int PAD = SUM_W - NUM_CH;

    generate
        if (PAD > 0) begin : g_pad
            assign summary_o = {{PAD{1'b0}}, cond};
        end else begin : g_full
            assign summary_o = cond;
        end
    endgenerate

    assign irq_o = |summary_o;

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cond == '0) |-> !irq_o); // R10
endmodule

// File: rtl/dmac_stat_top.sv
module dmac_stat_top
    import dmac_stat_pkg::*;
#(
    parameter int          NUM_CH  = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  SUM_OFS = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [NUM_CH-1:0] ev_buserr,
    input  logic [NUM_CH-1:0] ev_start,
    input  logic [NUM_CH-1:0] ev_end,
    input  logic [NUM_CH-1:0] start_ie,
    input  logic [NUM_CH-1:0] end_ie,
    input  logic [NUM_CH-1:0] beat_busy,
    input  logic [NUM_CH-1:0] req_pend,
    output logic              irq
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [WORD_W-1:0] words [NUM_CH];
    logic [NUM_CH-1:0] cond;
    logic [WORD_W-1:0] summary;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
            logic hit;
            assign hit = wr_en && (wr_addr == ADDR_W'(4 * gi));
            dmac_ch_status u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_hit     (hit),
                .wr_data    (wr_data),
                .ev_buserr  (ev_buserr[gi]),
                .ev_start   (ev_start[gi]),
                .ev_end     (ev_end[gi]),
                .start_ie   (start_ie[gi]),
                .end_ie     (end_ie[gi]),
                .beat_busy  (beat_busy[gi]),
                .req_pend   (req_pend[gi]),
                .status_o   (words[gi]),
                .irq_cond_o (cond[gi])
            );
        end
    endgenerate

    dmac_irq_merge #(.NUM_CH(NUM_CH), .SUM_W(WORD_W)) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond      (cond),
        .summary_o (summary),
        .irq_o     (irq)
    );

    logic [ADDR_W-3:0] rd_idx;
    assign rd_idx = rd_addr[ADDR_W-1:2];

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(SUM_OFS))
            rd_data = summary;
        else if (rd_addr[1:0] == 2'b00 && int'(rd_idx) < NUM_CH)
            rd_data = words[rd_idx[CH_W-1:0]];
    end
endmodule

// File: tb/dmac_stat_top_tb.sv
module dmac_stat_top_tb;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [N-1:0] ev_buserr = '0, ev_start = '0, ev_end = '0;
    logic [N-1:0] start_ie = '0, end_ie = '0, beat_busy = '0, req_pend = '0;
    logic irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0]  a;
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    dmac_stat_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_buserr(ev_buserr), .ev_start(ev_start), .ev_end(ev_end),
        .start_ie(start_ie), .end_ie(end_ie), .beat_busy(beat_busy),
        .req_pend(req_pend), .irq(irq)
    );

    // monitor: pops expected reads and compares
    initial begin
        forever begin
            wait (q.size() != 0);
            rd_addr = q[0].a;
            #1;
            total++;
            if (rd_data !== q[0].v) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h",
                         q[0].tag, q[0].a, rd_data, q[0].v);
            end
            q.delete(0);
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] v, input string tag);
        exp_t e;
        e.a = a; e.v = v; e.tag = tag;
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    task automatic expect_irq(input logic v, input string tag);
        total++;
        if (irq !== v) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, v);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state, R2 offsets
        expect_rd(8'h00, 32'h0000_0008, "R1 ch0");
        expect_rd(8'h7C, 32'h0000_0008, "R1 ch31");
        expect_rd(8'hF0, 32'h0, "R1 summary");
        expect_irq(1'b0, "R1 irq");

        // R7 run lag, R9 stop term via stop-interrupt enable
        wr(8'h04, 32'hA000_0000);
        expect_rd(8'h04, 32'hA000_0008, "R7 still stopped");
        expect_rd(8'hF0, 32'h0000_0002, "R9 stop term");
        expect_irq(1'b1, "R10 stop irq");
        idle(1);
        expect_rd(8'h04, 32'hA000_0000, "R7 running");
        expect_rd(8'hF0, 32'h0, "R9 stop term gone");

        // R3 bus error strobe
        @(negedge clk); ev_buserr[1] = 1'b1;
        @(negedge clk); ev_buserr[1] = 1'b0;
        idle(2);
        expect_rd(8'h04, 32'hA000_0001, "R3 sticky buserr");
        expect_rd(8'hF0, 32'h0000_0002, "R9 buserr term");
        expect_irq(1'b1, "R10 buserr irq");

        // R4 writing zero keeps flag
        wr(8'h04, 32'hA000_0000);
        expect_rd(8'h04, 32'hA000_0001, "R4 zero write keeps flag");
        // R6 write-back
        wr(8'h04, 32'hA000_0001);
        expect_rd(8'h04, 32'hA000_0000, "R6 write-back");
        expect_rd(8'hF0, 32'h0, "R6 summary clear");
        expect_irq(1'b0, "R10 quiet");

        // R9 start gating by descriptor enable
        @(negedge clk); ev_start[5] = 1'b1;
        @(negedge clk); ev_start[5] = 1'b0;
        expect_rd(8'h14, 32'h0000_000A, "R3 start flag");
        expect_rd(8'hF0, 32'h0, "R9 start masked");
        start_ie[5] = 1'b1;
        #1;
        expect_rd(8'hF0, 32'h0000_0020, "R9 start enabled");
        wr(8'h14, 32'h0000_0002);
        expect_rd(8'h14, 32'h0000_0008, "R4 start cleared");

        // R5 event and clear in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h14; wr_data = 32'h4; ev_end[5] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ev_end[5] = 1'b0;
        expect_rd(8'h14, 32'h0000_000C, "R5 event wins");
        expect_rd(8'hF0, 32'h0, "R9 end masked");
        wr(8'h14, 32'h0000_0004);
        expect_rd(8'h14, 32'h0000_0008, "R4 end cleared");

        // R4 read-only bits
        req_pend[31] = 1'b1;
        wr(8'h7C, 32'h0000_0108);
        expect_rd(8'h7C, 32'h0000_0108, "R4 read-only bits");
        req_pend[31] = 1'b0;
        wr(8'h7C, 32'h0000_0008);
        expect_rd(8'h7C, 32'h0000_0008, "R4 stopped ignores write");

        // R8 drain before stop
        beat_busy[1] = 1'b1;
        wr(8'h04, 32'h0);
        idle(3);
        expect_rd(8'h04, 32'h0, "R8 draining not stopped");
        beat_busy[1] = 1'b0;
        idle(2);
        expect_rd(8'h04, 32'h0000_0008, "R8 stopped after drain");

        // R10 two channels
        @(negedge clk); ev_buserr[0] = 1'b1; ev_buserr[31] = 1'b1;
        @(negedge clk); ev_buserr = '0;
        expect_rd(8'hF0, 32'h8000_0001, "R10 summary two bits");
        expect_irq(1'b1, "R10 shared line");
        wr(8'h00, 32'h1);
        wr(8'h7C, 32'h1);
        expect_irq(1'b0, "R10 cleared");

        // R11 summary and unmapped writes
        wr(8'hF0, 32'hFFFF_FFFF);
        wr(8'h80, 32'hFFFF_FFFF);
        expect_rd(8'h00, 32'h0000_0008, "R11 ch0 untouched");
        expect_rd(8'hF0, 32'h0, "R11 summary untouched");
        expect_rd(8'h80, 32'h0, "R11 unmapped read");

        // R2 no-descriptor-fetch bit
        wr(8'h00, 32'h4000_0000);
        expect_rd(8'h00, 32'h4000_0008, "R2 nodesc bit");

        finish_run();
    end
endmodule